// File: doc/BRIEF.md
# Host Register File with Message Queue

This block sits between a soft processor's word-addressed register bus and the image-analysis logic. Through it the processor reads a status word, pops 32-bit result words from a message queue, reads a fixed block identifier and sets the colour used to draw bounding boxes. The image logic side has a one-word-per-cycle push port that queues results without any handshake. When the queue is full, further pushes are dropped.

The bus is a plain strobe interface. A read strobe with an offset returns data on `bus_rdata` one clock later, and that value stays until the next read. A write strobe takes effect at the same clock edge. A read of the message offset is destructive: it pops the oldest word. Writing a 1 to the flush bit of the status word empties the queue in a single cycle.

Top module: `hostreg_top`

## Requirements
- R1: Word offsets decode as follows: 0 is status, 1 is the message pop port, 2 is the block identifier and 3 is the colour register. Read data appears on `bus_rdata` in the cycle after `bus_rd` and holds until the next read.
- R2: A status read returns the queue fill level in bits 15:8. All other bits read as zero, including the flush bit 4.
- R3: A write to offset 0 with bit 4 set empties the queue in one cycle, and a push in that same cycle is dropped. A write to offset 0 with bit 4 clear has no effect.
- R4: Reads of offset 1 return queued words oldest first, and each read lowers the fill level by one.
- R5: A read of offset 1 while the queue is empty returns 0 and leaves the fill level at 0.
- R6: The queue holds DEPTH words (64 by default). A push while full without a simultaneous pop is discarded, and the fill level and the stored words are left unchanged.
- R7: A push in the same cycle as a pop of offset 1 stores the pushed word while the pop returns the oldest word. This holds also when the queue is full; the level stays the same. On an empty queue the pop returns 0 and the level becomes 1.
- R8: The colour register is 24 bits wide and resets to 0x00FF00. A write to offset 3 loads `bus_wdata[23:0]`. A read of offset 3 returns the register zero-extended to 32 bits, and `box_colour` always shows the register.
- R9: Offset 2 reads the constant BLOCK_ID (default 0x5EE0B10C). Writes to offsets 1 and 2 change nothing.
- R10: After reset the queue is empty and `bus_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Word offset of the access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after `bus_rd` |
| push_valid | input | 1 | Push one word into the message queue |
| push_data | input | 32 | Word to push |
| box_colour | output | 24 | Current bounding-box colour |

## Verification
The queue is swept from empty to full one push at a time, with the status level read after every push. This separates level errors at each depth, including the 64-word full point, from errors in the status bit layout. Every word is then drained and checked in order against distinct arithmetic data, which exposes pointer wrap and ordering faults. Simultaneous push and pop are applied at both the full and the empty boundary, which tells a correct simultaneous path apart from plain push-drop or pop-empty handling. Flush is tried with the bit set and clear, and with a concurrent push. Writes to the read-only offsets are followed by reads that show whether anything changed.

// File: rtl/hostreg_pkg.sv
package hostreg_pkg;

  typedef enum logic [1:0] {
    OFS_STATUS = 2'd0,
    OFS_MSG    = 2'd1,
    OFS_ID     = 2'd2,
    OFS_COLOUR = 2'd3
  } hostreg_ofs_e;

  localparam int FLUSH_BIT = 4;
  localparam int LEVEL_LSB = 8;
  localparam int LEVEL_W   = 8;

  function automatic logic [31:0] status_word(input logic [LEVEL_W-1:0] level);
    logic [31:0] w;
    w = '0;
    w[LEVEL_LSB +: LEVEL_W] = level;
    return w;
  endfunction

endpackage

// File: rtl/hostreg_fifo.sv
module hostreg_fifo #(
  parameter int DEPTH  = 64,
  parameter int DATA_W = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  input  logic              flush,
  output logic [DATA_W-1:0] pop_data,
  output logic [CW-1:0]     level
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     rd_ptr, wr_ptr;
  logic              is_empty, is_full, pop_ok, push_ok;

  assign is_empty = (level == '0);
  assign is_full  = (level == CW'(DEPTH));
  assign pop_ok   = pop && !is_empty;
  // a pop in the same cycle frees a slot even when full; flush drops the push
  assign push_ok  = push && !flush && (!is_full || pop_ok);

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage without reset so it maps onto block RAM
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)       pop_data <= '0;
    else if (pop)  pop_data <= is_empty ? '0 : mem[rd_ptr];
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= next_ptr(wr_ptr);
      if (pop_ok)  rd_ptr <= next_ptr(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));

  a_r6_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
    (is_full && push && !pop && !flush) |=> (level == CW'(DEPTH)));

  a_r3_flush_empties: assert property (@(posedge clk) disable iff (rst)
    flush |=> (level == '0));

  a_r5_empty_pop_zero: assert property (@(posedge clk) disable iff (rst)
    (pop && is_empty && !flush) |=> (pop_data == '0));

  a_r7_pushpop_level: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !is_empty && !flush) |=> $stable(level));

endmodule

// File: rtl/hostreg_decode.sv
module hostreg_decode
  import hostreg_pkg::*;
(
  input  logic [1:0] addr,
  input  logic       rd,
  input  logic       wr,
  input  logic       flush_bit,
  output logic       pop_req,
  output logic       flush_req,
  output logic       colour_we
);

  hostreg_ofs_e ofs;
  assign ofs = hostreg_ofs_e'(addr);

  always_comb begin
    pop_req   = rd && (ofs == OFS_MSG);
    flush_req = wr && (ofs == OFS_STATUS) && flush_bit;
    colour_we = wr && (ofs == OFS_COLOUR);
  end

endmodule

// File: rtl/hostreg_top.sv
module hostreg_top
  import hostreg_pkg::*;
#(
  parameter int          DEPTH      = 64,
  parameter int          BUS_W      = 32,
  parameter int          COLOUR_W   = 24,
  parameter logic [23:0] COLOUR_RST = 24'h00FF00,
  parameter logic [31:0] BLOCK_ID   = 32'h5EE0_B10C
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [1:0]          bus_addr,
  input  logic                bus_rd,
  input  logic                bus_wr,
  input  logic [BUS_W-1:0]    bus_wdata,
  output logic [BUS_W-1:0]    bus_rdata,
  input  logic                push_valid,
  input  logic [BUS_W-1:0]    push_data,
  output logic [COLOUR_W-1:0] box_colour
);

  localparam int CW = $clog2(DEPTH + 1);

  logic             pop_req, flush_req, colour_we;
  logic [BUS_W-1:0] pop_data, rd_hold;
  logic [CW-1:0]    level;
  logic             sel_msg;
  logic             wdata_unused;

  assign wdata_unused = &bus_wdata[BUS_W-1:COLOUR_W];

  hostreg_decode dec_i (
    .addr      (bus_addr),
    .rd        (bus_rd),
    .wr        (bus_wr),
    .flush_bit (bus_wdata[FLUSH_BIT]),
    .pop_req   (pop_req),
    .flush_req (flush_req),
    .colour_we (colour_we)
  );

  hostreg_fifo #(.DEPTH(DEPTH), .DATA_W(BUS_W)) fifo_i (
    .clk       (clk),
    .rst       (rst),
    .push      (push_valid),
    .push_data (push_data),
    .pop       (pop_req),
    .flush     (flush_req),
    .pop_data  (pop_data),
    .level     (level)
  );

  always_ff @(posedge clk) begin
    if (rst)            box_colour <= COLOUR_RST[COLOUR_W-1:0];
    else if (colour_we) box_colour <= bus_wdata[COLOUR_W-1:0];
  end

  // registered read path; the queue word is already registered in the FIFO
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_msg <= 1'b0;
      rd_hold <= '0;
    end else if (bus_rd) begin
      sel_msg <= (hostreg_ofs_e'(bus_addr) == OFS_MSG);
      case (hostreg_ofs_e'(bus_addr))
        OFS_STATUS: rd_hold <= status_word(LEVEL_W'(level));
        OFS_ID:     rd_hold <= BLOCK_ID;
        OFS_COLOUR: rd_hold <= BUS_W'(box_colour);
        default:    rd_hold <= '0;
      endcase
    end
  end

  assign bus_rdata = sel_msg ? pop_data : rd_hold;

  a_r9_id_read: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd2) |=> (bus_rdata == BLOCK_ID));

  a_r2_status_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && bus_addr == 2'd0) |=> (bus_rdata[31:16] == '0 && bus_rdata[7:0] == '0));

  a_r8_colour_stable: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr == 2'd3) |=> $stable(box_colour));

  a_r1_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));

endmodule

// File: tb/hostreg_top_tb_top.sv
module hostreg_top_tb_top;

  localparam int          DEPTH    = 64;
  localparam logic [31:0] ID       = 32'h5EE0_B10C;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        push_valid = 1'b0;
  logic [31:0] push_data = '0;
  logic [23:0] box_colour;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hostreg_top dut_i (
    .clk, .rst, .bus_addr, .bus_rd, .bus_wr, .bus_wdata, .bus_rdata,
    .push_valid, .push_data, .box_colour
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pattern(input int i);
    return 32'hC3A5_0000 ^ (i * 32'h0101_0137);
  endfunction

  function automatic logic [31:0] status_of(input int lvl);
    return 32'(lvl) << 8;
  endfunction

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d, input bit with_push,
                           input logic [31:0] pd);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    push_valid = with_push; push_data = pd;
    @(negedge clk);
    bus_wr = 1'b0; push_valid = 1'b0;
  endtask

  task automatic push_word(input logic [31:0] d);
    @(negedge clk);
    push_valid = 1'b1; push_data = d;
    @(negedge clk);
    push_valid = 1'b0;
  endtask

  task automatic push_pop(input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    push_valid = 1'b1; push_data = d; bus_rd = 1'b1; bus_addr = 2'd1;
    @(negedge clk);
    push_valid = 1'b0; bus_rd = 1'b0;
    r = bus_rdata;
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    check("R10 rdata after reset", bus_rdata, 32'h0);
    bus_read(2'd0, d); check("R10 status after reset", d, status_of(0));
    bus_read(2'd3, d); check("R8 colour reset read", d, 32'h0000_FF00);
    check("R8 colour reset port", {8'h0, box_colour}, 32'h0000_FF00);
    bus_read(2'd2, d); check("R9 block id", d, ID);

    // empty pop
    bus_read(2'd1, d); check("R5 empty pop data", d, 32'h0);
    bus_read(2'd0, d); check("R5 level after empty pop", d, status_of(0));

    // fill sweep
    for (int i = 0; i < DEPTH; i++) begin
      push_word(pattern(i));
      bus_read(2'd0, d); check("R2 level during fill", d, status_of(i + 1));
    end
    push_word(32'hDEAD_BEEF);
    bus_read(2'd0, d); check("R6 push while full dropped", d, status_of(DEPTH));

    // push and pop together while full
    push_pop(pattern(DEPTH), d); check("R7 pushpop full returns oldest", d, pattern(0));
    bus_read(2'd0, d); check("R7 pushpop full level", d, status_of(DEPTH));

    // drain and check order
    for (int i = 1; i <= DEPTH; i++) begin
      bus_read(2'd1, d); check("R4 drain order", d, pattern(i));
      bus_read(2'd0, d); check("R4 level during drain", d, status_of(DEPTH - i));
    end
    bus_read(2'd1, d); check("R5 pop after drain", d, 32'h0);

    // push and pop together while empty
    push_pop(32'h1234_5678, d); check("R7 pushpop empty returns zero", d, 32'h0);
    bus_read(2'd0, d); check("R7 pushpop empty level", d, status_of(1));
    bus_read(2'd1, d); check("R7 pushed word kept", d, 32'h1234_5678);

    // flush
    for (int i = 0; i < 5; i++) push_word(pattern(100 + i));
    bus_write(2'd0, 32'hFFFF_FFEF, 1'b0, '0);
    bus_read(2'd0, d); check("R3 flush bit clear no effect", d, status_of(5));
    bus_write(2'd0, 32'h0000_0010, 1'b1, 32'hAAAA_5555);
    bus_read(2'd0, d); check("R3 flush empties, push dropped", d, status_of(0));
    bus_read(2'd1, d); check("R3 nothing left after flush", d, 32'h0);

    // read-only offsets ignore writes
    push_word(32'h0BAD_F00D);
    bus_write(2'd1, 32'hFFFF_FFFF, 1'b0, '0);
    bus_write(2'd2, 32'h0000_0000, 1'b0, '0);
    bus_read(2'd2, d); check("R9 id unchanged by write", d, ID);
    bus_read(2'd0, d); check("R9 level unchanged by write to msg", d, status_of(1));
    bus_read(2'd1, d); check("R9 queue content unchanged", d, 32'h0BAD_F00D);

    // colour register
    bus_write(2'd3, 32'hFFFF_FFFF, 1'b0, '0);
    bus_read(2'd3, d); check("R8 colour write read", d, 32'h00FF_FFFF);
    check("R8 colour port", {8'h0, box_colour}, 32'h00FF_FFFF);
    bus_write(2'd3, 32'h1234_5A6B, 1'b0, '0);
    bus_read(2'd3, d); check("R8 colour second write", d, 32'h0034_5A6B);

    // read data hold and offset decode
    bus_read(2'd2, d);
    repeat (3) @(negedge clk);
    check("R1 rdata held after read", bus_rdata, ID);
    bus_read(2'd3, d); check("R1 offset 3 decode", d, 32'h0034_5A6B);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule